// File: doc/BRIEF.md
# Two-Level Page Table Walker (32-bit virtual, 34-bit physical)

This block turns a 32-bit virtual address into a 34-bit physical address by reading page table entries from memory, one level at a time, across a two-level table whose levels each use a 10-bit index and 4-byte entries above a 12-bit page offset. A request carries the virtual address, the kind of access, the effective privilege and the two status flags that relax user-page access from supervisor mode and that let loads read executable pages. A separate translation-enable bit and a 22-bit root page number come from the translation control register.

For each level the walker issues one read on a simple request/acknowledge memory port. It then classifies the entry as a pointer, a legal leaf or a fault. When a legal leaf needs its accessed or dirty bit set, it writes the updated entry back before it answers. The answer is a one-cycle pulse that carries either the physical address and the read, write and execute permissions, or a fault flag. When translation is off, or the access is at machine level, the address passes straight through.

Top module: `sv32_walker`

## Requirements
- R1: `req_ready` is high only while the walker is idle. Each accepted request yields exactly one `rsp_valid` pulse, one cycle long. After reset the walker is idle with `rsp_valid` and `mem_req` low.
- R2: With `xlat_on` low, or with `req_priv` = 3 (machine), the response comes in the cycle after acceptance with no memory access, the address is `{2'b00, vaddr}`, no fault is flagged, and all three permissions are set.
- R3: The first entry read is at `root_ppn*4096 + vaddr[31:22]*4`. After a pointer, the second read is at `ppn*4096 + vaddr[21:12]*4`, where ppn = entry[31:10]. Entry flag bits are V=0, R=1, W=2, X=3, U=4, G=5, A=6, D=7.
- R4: An entry with V clear faults. An entry with R, W and X all clear at the last level also faults, because no level is left. A fault reports all permissions clear.
- R5: A valid leaf with W set and R clear is reserved and faults.
- R6: Privilege encoding is 0 user, 1 supervisor. A leaf with U set faults for a supervisor access, unless `req_sum` is set and the access is not a fetch. A leaf with U clear faults for a user access.
- R7: A leaf found at the top level whose entry bits [19:10] are not all zero faults.
- R8: Access encoding is 0 fetch, 1 load, 2 store. A load needs R, or X with `req_mxr` set. A store needs W. A fetch needs X.
- R9: On success the entry gets A set, and D set as well for a store. It is written back at the same address before the response, and only if its value changed. A fault writes nothing.
- R10: The physical address of a leaf is its ppn followed by the 12-bit offset. For a top-level leaf, bits [21:0] of the result come from the virtual address and bits [33:22] from entry[31:20].
- R11: The reported permissions are: read = R or (X and MXR); execute = X; write = W and (store or D).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Walker idle, request accepted this cycle if valid |
| req_vaddr | input | 32 | Virtual address |
| req_access | input | 2 | 0 fetch, 1 load, 2 store |
| req_priv | input | 2 | Effective privilege: 0 user, 1 supervisor, 3 machine |
| req_sum | input | 1 | Supervisor may touch user pages (not fetch) |
| req_mxr | input | 1 | Loads may read execute-only pages |
| xlat_on | input | 1 | 1 two-level translation, 0 bare |
| root_ppn | input | 22 | Root table page number |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 write-back, 0 entry read |
| mem_addr | output | 34 | Byte address of the entry |
| mem_wdata | output | 32 | Updated entry for write-back |
| mem_ack | input | 1 | Access done; read data valid the same cycle |
| mem_rdata | input | 32 | Entry read data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_fault | output | 1 | Translation fault |
| rsp_paddr | output | 34 | Physical address |
| rsp_r | output | 1 | Read permission |
| rsp_w | output | 1 | Write permission |
| rsp_x | output | 1 | Execute permission |

## Verification
A wrong level counter or table base shows up as a wrong entry address at the very next memory read, one cycle after the request or the pointer is taken. A misclassified entry shows up as a flipped fault flag or a wrong permission triple on the response that closes that walk. A bad write-back decision shows up as an extra or missing memory write, or a stale entry, before that response. The sweep crosses every combination of the V, R, W, X, U, A and D flags with each access kind, both privileges and both flag settings, at both levels, so each of these errors is seen within the walk that causes it.

// File: rtl/sv32_pkg.sv
package sv32_pkg;
  localparam int VA_W      = 32;
  localparam int PA_W      = 34;
  localparam int PTE_W     = 32;
  localparam int OFF_W     = 12;
  localparam int IDX_W     = 10;
  localparam int LEVELS    = 2;
  localparam int ENT_BYTES = 4;
  localparam int PPN_W     = PA_W - OFF_W;
  localparam int PPN_LSB   = 10;
  localparam int LVL_W     = (LEVELS > 1) ? $clog2(LEVELS) : 1;

  localparam int BV = 0;
  localparam int BR = 1;
  localparam int BW = 2;
  localparam int BX = 3;
  localparam int BU = 4;
  localparam int BA = 6;
  localparam int BD = 7;

  typedef enum logic [1:0] {ACC_FETCH = 2'd0, ACC_LOAD = 2'd1, ACC_STORE = 2'd2} acc_e;
  typedef enum logic [1:0] {PRIV_U = 2'd0, PRIV_S = 2'd1, PRIV_M = 2'd3} priv_e;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE, ST_RESP} walk_st_e;

  function automatic logic [PA_W-1:0] ppn_to_base(input logic [PPN_W-1:0] ppn);
    return {ppn, {OFF_W{1'b0}}};
  endfunction

  function automatic logic [IDX_W-1:0] va_index(input logic [VA_W-1:0] va,
                                               input logic [LVL_W-1:0] lvl);
    return va[OFF_W + int'(lvl)*IDX_W +: IDX_W];
  endfunction

  function automatic logic [PA_W-1:0] entry_addr(input logic [PA_W-1:0] base,
                                                input logic [IDX_W-1:0] idx);
    return base + PA_W'(idx) * PA_W'(ENT_BYTES);
  endfunction

  // ppn bits that must be zero for a leaf found at level lvl
  function automatic logic [PPN_W-1:0] ppn_low_mask(input logic [LVL_W-1:0] lvl);
    return (PPN_W'(1) << (int'(lvl)*IDX_W)) - PPN_W'(1);
  endfunction
endpackage

// File: rtl/sv32_pte_eval.sv
module sv32_pte_eval
  import sv32_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             check_en,
  input  logic [PTE_W-1:0] pte,
  input  logic [LVL_W-1:0] lvl,
  input  acc_e             acc,
  input  priv_e            priv,
  input  logic             sum,
  input  logic             mxr,
  output logic             is_ptr,
  output logic             fault,
  output logic             perm_r,
  output logic             perm_w,
  output logic             perm_x,
  output logic             wb_need,
  output logic [PTE_W-1:0] wb_pte
);
  logic v, r, w, x, u, d;
  logic rsvd, priv_bad, misal, acc_bad, no_level;

  always_comb begin
    v = pte[BV];
    r = pte[BR];
    w = pte[BW];
    x = pte[BX];
    u = pte[BU];
    d = pte[BD];
    is_ptr = v & ~r & ~w & ~x;
    no_level = is_ptr && (lvl == '0);
    rsvd = w & ~r;
    if (u) priv_bad = (priv != PRIV_U) && (!sum || acc == ACC_FETCH);
    else   priv_bad = (priv != PRIV_S);
    misal = (pte[PPN_LSB +: PPN_W] & ppn_low_mask(lvl)) != '0;
    case (acc)
      ACC_LOAD:  acc_bad = !(r || (x && mxr));
      ACC_STORE: acc_bad = !w;
      default:   acc_bad = !x;
    endcase
    fault = !v || no_level || (!is_ptr && (rsvd || priv_bad || misal || acc_bad));
    perm_r = r | (x & mxr);
    perm_x = x;
    perm_w = w & ((acc == ACC_STORE) | d);
    wb_pte = pte | (PTE_W'(1) << BA) | ((acc == ACC_STORE) ? (PTE_W'(1) << BD) : '0);
    wb_need = (wb_pte != pte);
  end

  // a leaf accepted without fault is valid and not a reserved encoding
  assert_leaf_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    check_en && !fault && !is_ptr |-> pte[BV] && (pte[BR] || !pte[BW]));
endmodule

// File: rtl/sv32_addr_unit.sv
module sv32_addr_unit
  import sv32_pkg::*;
(
  input  logic [PA_W-1:0]  base,
  input  logic [VA_W-1:0]  vaddr,
  input  logic [LVL_W-1:0] lvl,
  input  logic [PPN_W-1:0] leaf_ppn,
  output logic [PA_W-1:0]  ent_addr,
  output logic [PA_W-1:0]  leaf_paddr
);
  logic [PA_W-1:0] leaf_base;
  logic [PA_W-1:0] cand [LEVELS];

  assign leaf_base = ppn_to_base(leaf_ppn);

  // one candidate physical address per level: low bits kept from the VA
  generate
    for (genvar gl = 0; gl < LEVELS; gl++) begin : g_lvl
      localparam int KEEP = OFF_W + gl*IDX_W;
      localparam logic [PA_W-1:0] LOW = (PA_W'(1) << KEEP) - PA_W'(1);
      assign cand[gl] = (leaf_base & ~LOW) | (PA_W'(vaddr) & LOW);
    end
  endgenerate

  assign leaf_paddr = cand[lvl];
  assign ent_addr   = entry_addr(base, va_index(vaddr, lvl));
endmodule

// File: rtl/sv32_walker.sv
module sv32_walker
  import sv32_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_access,
  input  logic [1:0]       req_priv,
  input  logic             req_sum,
  input  logic             req_mxr,
  input  logic             xlat_on,
  input  logic [PPN_W-1:0] root_ppn,
  output logic             mem_req,
  output logic             mem_we,
  output logic [PA_W-1:0]  mem_addr,
  output logic [PTE_W-1:0] mem_wdata,
  input  logic             mem_ack,
  input  logic [PTE_W-1:0] mem_rdata,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_r,
  output logic             rsp_w,
  output logic             rsp_x
);
  walk_st_e         st;
  logic [VA_W-1:0]  va_q;
  acc_e             acc_q;
  priv_e            priv_q;
  logic             sum_q, mxr_q, pass_q;
  logic [LVL_W-1:0] lvl_q;
  logic [PA_W-1:0]  base_q;
  logic [PTE_W-1:0] wb_q;
  logic             fault_q, r_q, w_q, x_q;
  logic [PA_W-1:0]  paddr_q;

  // named internal events
  logic accept, ent_ack, take_ptr, take_fault, take_leaf, pass_req;
  logic is_ptr, e_fault, e_r, e_w, e_x, e_wb;
  logic [PTE_W-1:0] e_wb_pte;
  logic [PA_W-1:0]  leaf_paddr;

  sv32_pte_eval u_eval (
    .clk(clk), .rst_n(rst_n), .check_en(ent_ack),
    .pte(mem_rdata), .lvl(lvl_q), .acc(acc_q), .priv(priv_q),
    .sum(sum_q), .mxr(mxr_q),
    .is_ptr(is_ptr), .fault(e_fault), .perm_r(e_r), .perm_w(e_w), .perm_x(e_x),
    .wb_need(e_wb), .wb_pte(e_wb_pte)
  );

  sv32_addr_unit u_addr (
    .base(base_q), .vaddr(va_q), .lvl(lvl_q),
    .leaf_ppn(mem_rdata[PPN_LSB +: PPN_W]),
    .ent_addr(mem_addr), .leaf_paddr(leaf_paddr)
  );

  assign req_ready  = (st == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign pass_req   = !xlat_on || (priv_e'(req_priv) == PRIV_M);
  assign ent_ack    = (st == ST_READ) && mem_ack;
  assign take_fault = ent_ack && e_fault;
  assign take_ptr   = ent_ack && !e_fault && is_ptr;
  assign take_leaf  = ent_ack && !e_fault && !is_ptr;

  assign mem_req   = (st == ST_READ) || (st == ST_WRITE);
  assign mem_we    = (st == ST_WRITE);
  assign mem_wdata = wb_q;

  assign rsp_valid = (st == ST_RESP);
  assign rsp_fault = fault_q;
  assign rsp_paddr = paddr_q;
  assign rsp_r     = r_q;
  assign rsp_w     = w_q;
  assign rsp_x     = x_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      va_q    <= '0;
      acc_q   <= ACC_FETCH;
      priv_q  <= PRIV_U;
      sum_q   <= 1'b0;
      mxr_q   <= 1'b0;
      pass_q  <= 1'b0;
      lvl_q   <= '0;
      base_q  <= '0;
      wb_q    <= '0;
      fault_q <= 1'b0;
      r_q     <= 1'b0;
      w_q     <= 1'b0;
      x_q     <= 1'b0;
      paddr_q <= '0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          va_q   <= req_vaddr;
          acc_q  <= acc_e'(req_access);
          priv_q <= priv_e'(req_priv);
          sum_q  <= req_sum;
          mxr_q  <= req_mxr;
          pass_q <= pass_req;
          lvl_q  <= LVL_W'(LEVELS-1);
          base_q <= ppn_to_base(root_ppn);
          if (pass_req) begin
            paddr_q <= PA_W'(req_vaddr);
            fault_q <= 1'b0;
            {r_q, w_q, x_q} <= 3'b111;
            st <= ST_RESP;
          end else begin
            st <= ST_READ;
          end
        end
        ST_READ: begin
          if (take_fault) begin
            fault_q <= 1'b1;
            paddr_q <= '0;
            {r_q, w_q, x_q} <= 3'b000;
            st <= ST_RESP;
          end else if (take_ptr) begin
            base_q <= ppn_to_base(mem_rdata[PPN_LSB +: PPN_W]);
            lvl_q  <= lvl_q - LVL_W'(1);
          end else if (take_leaf) begin
            fault_q <= 1'b0;
            paddr_q <= leaf_paddr;
            {r_q, w_q, x_q} <= {e_r, e_w, e_x};
            wb_q <= e_wb_pte;
            st <= e_wb ? ST_WRITE : ST_RESP;
          end
        end
        ST_WRITE: if (mem_ack) st <= ST_RESP;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  assert_rsp_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_mem_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  assert_pass_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && pass_q |-> rsp_r && rsp_w && rsp_x && !rsp_fault);

  assert_store_writable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault && acc_q == ACC_STORE |-> rsp_w);

  assert_fetch_exec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault && acc_q == ACC_FETCH |-> rsp_x);

  assert_wb_accessed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[BA]);
endmodule

// File: tb/sv32_walker_bench.sv
module sv32_walker_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready;
  logic [31:0] req_vaddr;
  logic [1:0] req_access, req_priv;
  logic req_sum, req_mxr, xlat_on;
  logic [21:0] root_ppn;
  logic mem_req, mem_we, mem_ack;
  logic [33:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic rsp_valid, rsp_fault, rsp_r, rsp_w, rsp_x;
  logic [33:0] rsp_paddr;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  sv32_walker u_sv32_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_access(req_access), .req_priv(req_priv),
    .req_sum(req_sum), .req_mxr(req_mxr), .xlat_on(xlat_on), .root_ppn(root_ppn),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .rsp_r(rsp_r), .rsp_w(rsp_w),
    .rsp_x(rsp_x)
  );

  // memory model: 16 KiB of words, acknowledges one cycle after a request
  logic [31:0] mem [4096];
  int wr_cnt = 0;
  int rd_cnt = 0;
  logic [33:0] rd_last, rd_prev;
  always @(posedge clk) begin
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      if (mem_we) begin
        mem[mem_addr[13:2]] <= mem_wdata;
        wr_cnt <= wr_cnt + 1;
      end else begin
        mem_rdata <= mem[mem_addr[13:2]];
        rd_prev <= rd_last;
        rd_last <= mem_addr;
        rd_cnt <= rd_cnt + 1;
      end
    end else mem_ack <= 1'b0;
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  logic got_fault, got_r, got_w, got_x, busy_seen;
  logic [33:0] got_pa;
  int got_lat;

  task automatic walk(input logic [31:0] va, input int acc, input int prv,
                      input bit sm, input bit mx);
    int n;
    req_vaddr = va; req_access = 2'(acc); req_priv = 2'(prv);
    req_sum = sm; req_mxr = mx; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    busy_seen = !req_ready;
    n = 1;
    while (!rsp_valid && n < 200) begin
      @(negedge clk);
      n++;
    end
    got_lat = n;
    got_fault = rsp_fault; got_pa = rsp_paddr;
    got_r = rsp_r; got_w = rsp_w; got_x = rsp_x;
    @(negedge clk);
  endtask

  // bench restatement of the leaf rules
  function automatic void model(input logic [31:0] pte, input int lv, input int a,
      input int p, input bit sm, input bit mx, input logic [31:0] va,
      output bit flt, output string tag, output logic [33:0] pa,
      output logic [2:0] rwx, output logic [31:0] npte);
    bit fv, fr, fw, fx, fu, fd, bad_priv, bad_acc;
    fv = pte[0]; fr = pte[1]; fw = pte[2]; fx = pte[3]; fu = pte[4]; fd = pte[7];
    bad_priv = fu ? (p != 0 && (!sm || a == 0)) : (p != 1);
    if (a == 1) bad_acc = !(fr || (fx && mx));
    else if (a == 2) bad_acc = !fw;
    else bad_acc = !fx;
    flt = 1'b1;
    if (!fv || (!fr && !fw && !fx)) tag = "R4";
    else if (fw && !fr) tag = "R5";
    else if (bad_priv) tag = "R6";
    else if (lv == 1 && pte[19:10] != 10'd0) tag = "R7";
    else if (bad_acc) tag = "R8";
    else begin flt = 1'b0; tag = "R8"; end
    if (lv == 1) pa = {pte[31:20], va[21:0]};
    else pa = {pte[31:10], va[11:0]};
    rwx = {fr | (fx & mx), fw & ((a == 2) | fd), fx};
    npte = pte | 32'h40 | ((a == 2) ? 32'h80 : 32'h0);
  endfunction

  initial begin
    #(20 * 190000);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cnt, wb0, rd0;
    bit ef;
    string et;
    logic [33:0] epa;
    logic [2:0] erwx;
    logic [31:0] enew, pte, va;
    logic [9:0] i1, i0;
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_access = '0; req_priv = '0;
    req_sum = 1'b0; req_mxr = 1'b0; xlat_on = 1'b0; root_ppn = 22'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset ready", 64'(req_ready), 64'd1);
    check("R1 reset rsp", 64'(rsp_valid), 64'd0);
    check("R1 reset mem", 64'(mem_req), 64'd0);

    // R2 pass-through: bare mode and machine level
    rd0 = rd_cnt;
    walk(32'hDEAD_BEEF, 2, 1, 1'b0, 1'b0);
    check("R2 bare pa", 64'(got_pa), 64'h0_DEAD_BEEF);
    check("R2 bare perm", 64'({got_fault, got_r, got_w, got_x}), 64'b0111);
    check("R2 bare latency", 64'(got_lat), 64'd1);
    check("R1 busy after accept", 64'(busy_seen), 64'd1);
    xlat_on = 1'b1;
    walk(32'h1234_5678, 0, 3, 1'b0, 1'b0);
    check("R2 machine pa", 64'(got_pa), 64'h0_1234_5678);
    check("R2 machine perm", 64'({got_fault, got_r, got_w, got_x}), 64'b0111);
    check("R2 no reads", 64'(rd_cnt - rd0), 64'd0);

    // sweep of entry flags, access kinds, privileges and status flags
    cnt = 0;
    for (int lv = 0; lv < 2; lv++)
      for (int f = 0; f < 128; f++)
        for (int a = 0; a < 3; a++)
          for (int p = 0; p < 2; p++)
            for (int sm = 0; sm < 4; sm++) begin
              if (lv == 1 && f[0] && f[3:1] == 3'b000) continue;
              cnt++;
              i1 = 10'(37 + cnt * 7);
              i0 = 10'(5 + cnt * 13);
              va = {i1, i0, 12'(cnt * 91)};
              if (lv == 0) begin
                pte = {22'(32'h2A5C3 + cnt * 17), f[6], f[5], 1'b0, f[4:0]};
                mem[12'h400 + 12'(i1)] = {22'd2, 10'h001};
                mem[12'h800 + 12'(i0)] = pte;
              end else begin
                pte = {12'(12'h09A + cnt * 3), (cnt % 8 < 2) ? 10'(cnt | 1) : 10'd0,
                       f[6], f[5], 1'b0, f[4:0]};
                mem[12'h400 + 12'(i1)] = pte;
              end
              wb0 = wr_cnt;
              walk(va, a, p, sm[0], sm[1]);
              model(pte, lv, a, p, sm[0], sm[1], va, ef, et, epa, erwx, enew);
              check({et, " fault"}, 64'(got_fault), 64'(ef));
              if (lv == 0) begin
                check("R3 first read", 64'(rd_prev), 64'(34'h1000 + 34'(i1) * 4));
                check("R3 second read", 64'(rd_last), 64'(34'h2000 + 34'(i0) * 4));
              end else begin
                check("R3 top read", 64'(rd_last), 64'(34'h1000 + 34'(i1) * 4));
              end
              if (ef) begin
                check("R4 fault perms", 64'({got_r, got_w, got_x}), 64'd0);
                check("R9 no write on fault", 64'(wr_cnt - wb0), 64'd0);
              end else begin
                check("R10 paddr", 64'(got_pa), 64'(epa));
                check("R11 perms", 64'({got_r, got_w, got_x}), 64'(erwx));
                check("R9 write count", 64'(wr_cnt - wb0), 64'(enew != pte));
                if (lv == 0) check("R9 entry", 64'(mem[12'h800 + 12'(i0)]), 64'(enew));
                else check("R9 entry", 64'(mem[12'h400 + 12'(i1)]), 64'(enew));
              end
            end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule